// File: doc/BRIEF.md
# NAND Bus Strobe Timing Generator

This block converts single byte-wide requests into cycles on a NAND flash bus. There are four request kinds: command write, address write, data write and data read. For each request the block drives the latch enables, the write and read strobes, the chip enable and the data bus direction. Every phase length comes from one packed 32-bit timing word, which is held static while the block runs. The timing word sets the active and recovery times of both strobes, a bus turnaround gap, a chip-enable lead time and a hold-off before the ready/busy line is sampled.

A requester hands over one operation through a valid/ready pair. It then receives a completion through a second valid/ready pair, which also carries the byte captured on a read. A write may be flagged as one that starts a busy period. In that case the block waits out the hold-off, then waits for the ready/busy line to go high before it reports completion. A combined ready output is high only when the flash reports ready and the block is idle.

Top module: `nand_strobe_gen`

## Requirements
- R1: After reset, chip enable, both strobes and both latch enables are inactive (nCE, nWE and nRE high; CLE and ALE low), the data bus is not driven, no completion is pending and a request is accepted.
- R2: Op code 0 (command) runs a write cycle with CLE high. nWE is low for wr_lo+1 cycles, then high for wr_hi+1 cycles. wr_lo is timing bits 3:0 and wr_hi is bits 7:4. The request byte is driven on the bus throughout.
- R3: Op code 1 (address) runs the same write cycle with ALE high and CLE low. Op code 2 (data write) runs it with both latch enables low.
- R4: Op code 3 (read) holds nRE low for rd_lo+1 cycles, then high for rd_hi+1 cycles. rd_lo is bits 11:8 and rd_hi is bits 15:12. The bus is not driven. The returned byte is the bus value sampled at the edge where nRE rises.
- R5: Before the first strobe of each operation, nCE is held low for ce_dly cycles (bits 25:24) with both strobes high. When ce_dly is 0 this phase is skipped.
- R6: When an operation's direction (read or write) differs from the previous operation, a turnaround of ta cycles (bits 18:16) is inserted first, with nCE high and the bus released. There is no turnaround when the direction is unchanged or when ta is 0. The direction after reset counts as write.
- R7: After a write flagged to start a busy period, the ready/busy line is ignored for bsy cycles (bits 23:19) after the strobe recovery. The flag has no effect on reads.
- R8: After that hold-off, completion waits until the ready/busy line is sampled high.
- R9: A completion stays valid, with stable data, until it is accepted. Requests are accepted only while the block is idle.
- R10: The ready output is high exactly when the block is idle and the ready/busy line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| timing_i | input | 32 | Packed phase-length word (static) |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_op_i | input | 2 | 0 command, 1 address, 2 data write, 3 data read |
| req_data_i | input | 8 | Byte to write |
| req_wait_i | input | 1 | Write starts a busy period |
| rsp_valid_o | output | 1 | Completion valid |
| rsp_ready_i | input | 1 | Completion accepted |
| rsp_data_o | output | 8 | Byte captured by a read |
| ready_o | output | 1 | Flash ready and block idle |
| nand_ce_no | output | 1 | Chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Bus data out |
| nand_dq_oe_o | output | 1 | Bus drive enable |
| nand_dq_i | input | 8 | Bus data in |
| nand_rb_i | input | 1 | Ready/busy line, high is ready |

## Verification
A wrong phase state or counter value shows up on the pins within one clock. A strobe edge lands a cycle early or late, a latch enable appears on the wrong op, or nCE toggles out of place. The reference model predicts every pin on every cycle, so a slip is caught in the cycle it occurs. A stale direction flag shows up as an added or missing turnaround at the start of the next operation. A ready/busy line sampled too early makes completion arrive during the hold-off, while the line is still high and before the model expects it.

// File: rtl/nsg_pkg.sv
package nsg_pkg;
  localparam int unsigned TIM_W = 32;
  localparam int unsigned CNT_W = 5;

  typedef enum logic [1:0] {OP_CMD = 2'd0, OP_ADDR = 2'd1, OP_WDATA = 2'd2, OP_RDATA = 2'd3} op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TURN, ST_CE, ST_LOW, ST_HIGH, ST_BDLY, ST_BWAIT, ST_RESP
  } st_e;

  // field order follows bit positions of the timing word, msb first
  typedef struct packed {
    logic [1:0] ce_dly;
    logic [4:0] bsy_dly;
    logic [2:0] turn;
    logic [3:0] rd_hi;
    logic [3:0] rd_lo;
    logic [3:0] wr_hi;
    logic [3:0] wr_lo;
  } tim_t;

  localparam int unsigned TIM_USED = $bits(tim_t);
endpackage

// File: rtl/nsg_phase_sel.sv
module nsg_phase_sel
  import nsg_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic [TIM_W-1:0] timing_i,
  input  logic             is_rd_i,
  output logic [W-1:0]     lo_len_o,
  output logic [W-1:0]     hi_len_o,
  output logic [W-1:0]     ta_len_o,
  output logic [W-1:0]     bsy_len_o,
  output logic [W-1:0]     ce_len_o
);
  tim_t tim;
  logic unused_hi;

  assign tim       = tim_t'(timing_i[TIM_USED-1:0]);
  assign unused_hi = ^timing_i[TIM_W-1:TIM_USED];

  assign lo_len_o  = is_rd_i ? W'(tim.rd_lo) : W'(tim.wr_lo);
  assign hi_len_o  = is_rd_i ? W'(tim.rd_hi) : W'(tim.wr_hi);
  assign ta_len_o  = W'(tim.turn);
  assign bsy_len_o = W'(tim.bsy_dly);
  assign ce_len_o  = W'(tim.ce_dly);
endmodule

// File: rtl/nsg_phase_cnt.sv
module nsg_phase_cnt #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/nsg_pin_drive.sv
module nsg_pin_drive
  import nsg_pkg::*;
(
  input  st_e  st_i,
  input  op_e  op_i,
  output logic ce_no,
  output logic cle_o,
  output logic ale_o,
  output logic we_no,
  output logic re_no,
  output logic oe_o
);
  logic access, is_rd;

  assign access = (st_i == ST_CE) || (st_i == ST_LOW) || (st_i == ST_HIGH);
  assign is_rd  = (op_i == OP_RDATA);

  assign ce_no = (st_i == ST_IDLE) || (st_i == ST_TURN);
  assign cle_o = access && (op_i == OP_CMD);
  assign ale_o = access && (op_i == OP_ADDR);
  assign oe_o  = access && !is_rd;
  assign we_no = !((st_i == ST_LOW) && !is_rd);
  assign re_no = !((st_i == ST_LOW) && is_rd);
endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
  import nsg_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIM_W-1:0]  timing_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic              req_wait_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              ready_o,
  output logic              nand_ce_no,
  output logic              nand_cle_o,
  output logic              nand_ale_o,
  output logic              nand_we_no,
  output logic              nand_re_no,
  output logic [DATA_W-1:0] nand_dq_o,
  output logic              nand_dq_oe_o,
  input  logic [DATA_W-1:0] nand_dq_i,
  input  logic              nand_rb_i
);
  st_e  st_q, st_d;
  op_e  op_q, op_cur;
  logic [DATA_W-1:0] data_q, rdata_q;
  logic wait_q, last_rd_q;
  logic ld, cnt_zero;
  logic [CNT_W-1:0] ld_val, lo_len, hi_len, ta_len, bsy_len, ce_len;
  st_e  entry_st;
  logic [CNT_W-1:0] entry_val;
  logic accept, new_rd, turn_need;

  assign op_cur    = (st_q == ST_IDLE) ? op_e'(req_op_i) : op_q;
  assign accept    = (st_q == ST_IDLE) && req_valid_i;
  assign new_rd    = (op_e'(req_op_i) == OP_RDATA);
  assign turn_need = (new_rd != last_rd_q) && (ta_len != '0);

  nsg_phase_sel #(.W(CNT_W)) u_sel (
    .timing_i (timing_i),
    .is_rd_i  (op_cur == OP_RDATA),
    .lo_len_o (lo_len),
    .hi_len_o (hi_len),
    .ta_len_o (ta_len),
    .bsy_len_o(bsy_len),
    .ce_len_o (ce_len)
  );

  nsg_phase_cnt #(.W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(ld),
    .val_i (ld_val),
    .zero_o(cnt_zero)
  );

  // entry into the access: chip-enable lead time, or straight to the strobe
  always_comb begin
    if (ce_len != '0) begin
      entry_st  = ST_CE;
      entry_val = ce_len - CNT_W'(1);
    end else begin
      entry_st  = ST_LOW;
      entry_val = lo_len;
    end
  end

  always_comb begin
    st_d   = st_q;
    ld     = 1'b0;
    ld_val = '0;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) begin
        ld = 1'b1;
        if (turn_need) begin
          st_d   = ST_TURN;
          ld_val = ta_len - CNT_W'(1);
        end else begin
          st_d   = entry_st;
          ld_val = entry_val;
        end
      end
      ST_TURN: if (cnt_zero) begin
        st_d = entry_st; ld = 1'b1; ld_val = entry_val;
      end
      ST_CE: if (cnt_zero) begin
        st_d = ST_LOW; ld = 1'b1; ld_val = lo_len;
      end
      ST_LOW: if (cnt_zero) begin
        st_d = ST_HIGH; ld = 1'b1; ld_val = hi_len;
      end
      ST_HIGH: if (cnt_zero) begin
        if (wait_q && (op_q != OP_RDATA)) begin
          if (bsy_len != '0) begin
            st_d = ST_BDLY; ld = 1'b1; ld_val = bsy_len - CNT_W'(1);
          end else begin
            st_d = ST_BWAIT;
          end
        end else begin
          st_d = ST_RESP;
        end
      end
      ST_BDLY:  if (cnt_zero) st_d = ST_BWAIT;
      ST_BWAIT: if (nand_rb_i) st_d = ST_RESP;
      ST_RESP:  if (rsp_ready_i) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      op_q      <= OP_CMD;
      data_q    <= '0;
      wait_q    <= 1'b0;
      last_rd_q <= 1'b0;
      rdata_q   <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        op_q      <= op_e'(req_op_i);
        data_q    <= req_data_i;
        wait_q    <= req_wait_i;
        last_rd_q <= new_rd;
      end
      // sample at the edge where nRE rises
      if (st_q == ST_LOW && cnt_zero && op_q == OP_RDATA) rdata_q <= nand_dq_i;
    end
  end

  nsg_pin_drive u_pins (
    .st_i (st_q),
    .op_i (op_q),
    .ce_no(nand_ce_no),
    .cle_o(nand_cle_o),
    .ale_o(nand_ale_o),
    .we_no(nand_we_no),
    .re_no(nand_re_no),
    .oe_o (nand_dq_oe_o)
  );

  assign nand_dq_o   = data_q;
  assign req_ready_o = (st_q == ST_IDLE);
  assign rsp_valid_o = (st_q == ST_RESP);
  assign rsp_data_o  = rdata_q;
  assign ready_o     = (st_q == ST_IDLE) && nand_rb_i;
endmodule

// File: rtl/nsg_checker.sv
module nsg_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [DATA_W-1:0] rsp_data_o,
  input logic              ready_o,
  input logic              nand_ce_no,
  input logic              nand_cle_o,
  input logic              nand_ale_o,
  input logic              nand_we_no,
  input logic              nand_re_no,
  input logic              nand_dq_oe_o,
  input logic              nand_rb_i
);
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!nand_we_no && !nand_re_no)); // R4
  AST_LATCH_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nand_cle_o && nand_ale_o)); // R3
  AST_STROBE_UNDER_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_we_no || !nand_re_no) |-> !nand_ce_no); // R5
  AST_READ_BUS_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_re_no |-> !nand_dq_oe_o); // R4
  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_data_o))); // R9
  AST_REQ_ONLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (nand_ce_no && !rsp_valid_o)); // R9
  AST_READY_NEEDS_RB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (nand_rb_i && req_ready_o)); // R10
endmodule

bind nand_strobe_gen nsg_checker #(.DATA_W(DATA_W)) u_nsg_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ready_i (rsp_ready_i),
  .rsp_data_o  (rsp_data_o),
  .ready_o     (ready_o),
  .nand_ce_no  (nand_ce_no),
  .nand_cle_o  (nand_cle_o),
  .nand_ale_o  (nand_ale_o),
  .nand_we_no  (nand_we_no),
  .nand_re_no  (nand_re_no),
  .nand_dq_oe_o(nand_dq_oe_o),
  .nand_rb_i   (nand_rb_i)
);

// File: tb/tb_nand_strobe_gen.sv
`timescale 1ns/1ps
module tb_nand_strobe_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] timing;
  logic req_valid = 1'b0, req_wait = 1'b0, rsp_ready = 1'b0, rb = 1'b1;
  logic [1:0] req_op = 2'd0;
  logic [7:0] req_data = 8'h00, dq_in = 8'h00;
  logic req_ready, rsp_valid, ready, ce_n, cle, ale, we_n, re_n, dq_oe;
  logic [7:0] rsp_data, dq_out;

  int compared = 0, mismatched = 0;
  bit done = 0;
  int wlo, whi, rlo, rhi, ta, bsy, tcea;
  bit last_rd_m = 0;

  always #10 clk = ~clk;

  nand_strobe_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .timing_i(timing),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_data_i(req_data), .req_wait_i(req_wait),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_data_o(rsp_data),
    .ready_o(ready), .nand_ce_no(ce_n), .nand_cle_o(cle), .nand_ale_o(ale),
    .nand_we_no(we_n), .nand_re_no(re_n), .nand_dq_o(dq_out),
    .nand_dq_oe_o(dq_oe), .nand_dq_i(dq_in), .nand_rb_i(rb)
  );

  task automatic set_timing(input int a_wlo, a_whi, a_rlo, a_rhi, a_ta, a_bsy, a_ce);
    wlo = a_wlo; whi = a_whi; rlo = a_rlo; rhi = a_rhi; ta = a_ta; bsy = a_bsy; tcea = a_ce;
    timing = {6'd0, 2'(a_ce), 5'(a_bsy), 3'(a_ta), 4'(a_rhi), 4'(a_rlo), 4'(a_whi), 4'(a_wlo)};
  endtask

  // {req_ready, ce_n, cle, ale, we_n, re_n, oe, rsp_valid}
  task automatic check_vec(input logic [7:0] exp, input string tag);
    logic [7:0] act;
    act = {req_ready, ce_n, cle, ale, we_n, re_n, dq_oe, rsp_valid};
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: pins act=%b exp=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_val(input logic [7:0] act, input logic [7:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic phase(input int n, input logic [7:0] v, input string tag,
                       input bit drop, input logic [7:0] d);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      check_vec(v, tag);
      if (v[1]) check_val(dq_out, d, {tag, " bus data"});
      if (drop && i == n - 1) rb = 1'b0;
    end
  endtask

  task automatic xfer(input logic [1:0] op, input logic [7:0] d, input bit w,
                      input int rbd, input logic [7:0] rv, input string tag);
    bit rd, c, a, bw, turn;
    int lo, hi;
    rd = (op == 2'd3); c = (op == 2'd0); a = (op == 2'd1);
    bw = w && !rd;
    lo = rd ? rlo : wlo;
    hi = rd ? rhi : whi;
    turn = (rd != last_rd_m) && (ta > 0);
    last_rd_m = rd;
    dq_in = rv;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_data = d; req_wait = w;
    check_vec(8'b1100_1100, {tag, " R9 idle before request"});
    @(posedge clk);
    if (turn) phase(ta, 8'b0100_1100, "R6 turnaround", 0, d);
    if (tcea > 0) phase(tcea, {2'b00, c, a, 2'b11, !rd, 1'b0}, "R5 ce setup", 0, d);
    phase(lo + 1, {2'b00, c, a, rd, !rd, !rd, 1'b0}, {tag, " strobe low"}, 0, d);
    phase(hi + 1, {2'b00, c, a, 2'b11, !rd, 1'b0}, {tag, " strobe high"}, bw && bsy == 0, d);
    if (bw) begin
      if (bsy > 0) phase(bsy, 8'b0000_1100, "R7 busy hold-off", 1, d);
      for (int i = 0; i < rbd; i++) begin
        @(negedge clk);
        check_vec(8'b0000_1100, "R8 busy wait");
        check_val({7'd0, ready}, 8'd0, "R10 ready low while busy");
        if (i == rbd - 1) rb = 1'b1;
      end
    end
    @(negedge clk);
    check_vec(8'b0000_1101, {tag, " R9 completion"});
    if (rd) check_val(rsp_data, rv, "R4 read capture");
    @(negedge clk);
    check_vec(8'b0000_1101, "R9 completion held");
    if (rd) check_val(rsp_data, rv, "R9 data held");
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    check_vec(8'b1100_1100, {tag, " back to idle"});
    check_val({7'd0, ready}, 8'd1, "R10 ready when idle");
  endtask

  initial begin
    set_timing(2, 1, 3, 2, 2, 4, 1);
    repeat (3) @(negedge clk);
    check_vec(8'b1100_1100, "R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check_vec(8'b1100_1100, "R1 after reset");
    check_val({7'd0, ready}, 8'd1, "R10 ready after reset");

    xfer(2'd0, 8'h70, 1'b0, 0, 8'h00, "R2 command");
    xfer(2'd1, 8'h3C, 1'b0, 0, 8'h00, "R3 address");
    xfer(2'd2, 8'hA5, 1'b0, 0, 8'h00, "R3 data write");
    xfer(2'd0, 8'h10, 1'b1, 3, 8'h00, "R7 busy command");
    xfer(2'd3, 8'h00, 1'b0, 0, 8'h5A, "R4 read after write");
    xfer(2'd3, 8'h00, 1'b1, 0, 8'hC3, "R4 read same dir, wait flag ignored R7");
    xfer(2'd2, 8'h81, 1'b0, 0, 8'h00, "R6 write after read");

    @(negedge clk); rb = 1'b0;
    @(negedge clk);
    check_val({7'd0, ready}, 8'd0, "R10 ready low when rb low");
    rb = 1'b1;

    set_timing(0, 0, 1, 0, 0, 0, 0);
    xfer(2'd0, 8'hFF, 1'b1, 1, 8'h00, "R8 busy no hold-off");
    xfer(2'd3, 8'h00, 1'b0, 0, 8'h96, "R6 no turnaround when ta zero");
    set_timing(5, 3, 0, 4, 7, 2, 3);
    xfer(2'd1, 8'h01, 1'b0, 0, 8'h00, "R5 long ce setup address");
    xfer(2'd3, 8'h00, 1'b0, 0, 8'h24, "R4 max turnaround read");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule